// File: doc/BRIEF.md
# Sliding and Block Sample Window Acquisition

This block sits between an ADC sample stream and two detectors. After reset it waits in an idle state. The first valid sample starts the preamble phase. In that phase the block keeps a circular store of the last `WIN_LEN` samples. From the `WIN_LEN`-th sample on, every new sample produces a window for the preamble detector. Each window is the previous one moved on by exactly one sample. After `PRE_WINDOWS` such windows the block stops and waits for the detector's alignment result.

The result arrives as a one-cycle `align_valid` pulse that carries the alignment offset `align_delay`. The block latches the offset and arms its data phase. The first sample after arming loads the guard counter and is thrown away. While the counter is nonzero, each further sample is thrown away and decrements it. In total, `align_delay + 1` samples are skipped, which cancels the samples taken too early during alignment. After the skip, the block hands the symbol detector non-overlapping blocks of `WIN_LEN` consecutive samples until `restart` returns it to idle.

States: `ST_IDLE` (first sample → `ST_PRE`), `ST_PRE` (last preamble window → `ST_PRE_WAIT`), `ST_PRE_WAIT` (`align_valid` → `ST_ARM`), `ST_ARM` (sample with latched offset 0 → `ST_DATA`, otherwise → `ST_GUARD`), `ST_GUARD` (sample with counter 1 → `ST_DATA`), `ST_DATA` (stays there). `restart` takes every state to `ST_IDLE`.

Top module: `sample_window_acq`

## Requirements
- R1: After reset both window valid outputs are low. The block is idle, and the first valid sample counts as sample one of the preamble.
- R2: Every window is ordered oldest first. Entry 0 (least significant `SAMPLE_W` bits) holds the oldest sample and entry `WIN_LEN-1` holds the sample accepted in the cycle before the valid pulse. The first preamble window comes out on the `WIN_LEN`-th preamble sample.
- R3: Each later preamble window is the previous window moved down by one entry, with the new sample in entry `WIN_LEN-1`.
- R4: Exactly `PRE_WINDOWS` preamble windows are produced. Samples that arrive after the last one and before alignment produce no window.
- R5: `align_valid` has an effect only while the block is waiting after the preamble. A pulse at any other time is ignored.
- R6: After alignment, exactly `align_delay + 1` valid samples are discarded and appear in no window. The offset is the `align_delay` value present with the accepted `align_valid` pulse.
- R7: In the data phase, every `WIN_LEN` consecutive samples after the skip form one data window. Data windows do not share any sample.
- R8: Each window valid is a one-cycle pulse. It is registered one cycle after the sample that completes the window. The two valids are never high together.
- R9: A `restart` cycle returns the block to idle and clears its counters and indices. The next sample then starts a new preamble, and no window comes out in the cycle after `restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Synchronous return to idle |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Sample value |
| align_valid | input | 1 | Alignment result pulse |
| align_delay | input | DELAY_W | Alignment offset in samples |
| pre_win_valid | output | 1 | Preamble window pulse |
| pre_win | output | WIN_LEN*SAMPLE_W | Preamble window, entry 0 oldest |
| dat_win_valid | output | 1 | Data window pulse |
| dat_win | output | WIN_LEN*SAMPLE_W | Data window, entry 0 oldest |

## Verification
The bench builds the block with `SAMPLE_W` 12, `WIN_LEN` 8, `DELAY_W` 3 and `PRE_WINDOWS` cut to 12. The short preamble allows several full preamble runs in one test, each separated by a `restart`. The 3-bit offset covers the smallest skip (offset 0, one sample) and the largest (offset 7, eight samples). It also allows a stray alignment pulse to be sent both during the preamble and during the data phase.

// File: rtl/swa_pkg.sv
package swa_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_PRE_WAIT,
        ST_ARM,
        ST_GUARD,
        ST_DATA
    } swa_state_e;
endpackage

// File: rtl/swa_ring.sv
module swa_ring #(
    parameter int SAMPLE_W = 12,
    parameter int WIN_LEN  = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clr,
    input  logic                               wr_en,
    input  logic [SAMPLE_W-1:0]                wr_data,
    output logic [WIN_LEN-1:0][SAMPLE_W-1:0]   next_win
);
    localparam int IDX_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

    logic [SAMPLE_W-1:0] mem_r [WIN_LEN];
    logic [IDX_W-1:0]    head_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_r <= '0;
            for (int k = 0; k < WIN_LEN; k++) mem_r[k] <= '0;
        end else if (clr) begin
            head_r <= '0;
        end else if (wr_en) begin
            mem_r[head_r] <= wr_data;
            head_r <= (head_r == IDX_W'(WIN_LEN-1)) ? '0 : head_r + 1'b1;
        end
    end

    // Window as it will be after the pending write: oldest slot is head+1.
    for (genvar i = 0; i < WIN_LEN; i++) begin : g_order
        if (i == WIN_LEN-1) begin : g_newest
            assign next_win[i] = wr_data;
        end else begin : g_older
            logic [IDX_W:0] sum;
            logic [IDX_W-1:0] idx;
            always_comb begin
                sum = {1'b0, head_r} + (IDX_W+1)'(i + 1);
                if (sum >= (IDX_W+1)'(WIN_LEN)) sum = sum - (IDX_W+1)'(WIN_LEN);
                idx = sum[IDX_W-1:0];
            end
            assign next_win[i] = mem_r[idx];
        end
    end
endmodule

// File: rtl/swa_ctrl.sv
module swa_ctrl
    import swa_pkg::*;
#(
    parameter int WIN_LEN     = 8,
    parameter int PRE_WINDOWS = 112,
    parameter int DELAY_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               smp_valid,
    input  logic               align_valid,
    input  logic [DELAY_W-1:0] align_delay,
    output logic               wr_en,
    output logic               emit_pre,
    output logic               emit_dat
);
    localparam int CNT_W    = $clog2(WIN_LEN + PRE_WINDOWS + 1);
    localparam int LAST_PRE = WIN_LEN + PRE_WINDOWS - 2;

    swa_state_e          st_r, st_nxt;
    logic [CNT_W-1:0]    cnt_r;
    logic [DELAY_W-1:0]  dly_hold_r;
    logic [DELAY_W-1:0]  dly_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_r <= ST_IDLE;
        else        st_r <= st_nxt;
    end

    always_comb begin
        st_nxt   = st_r;
        wr_en    = 1'b0;
        emit_pre = 1'b0;
        emit_dat = 1'b0;
        unique case (st_r)
            ST_IDLE: begin
                if (smp_valid) begin
                    wr_en  = 1'b1;
                    st_nxt = ST_PRE;
                end
            end
            ST_PRE: begin
                if (smp_valid) begin
                    wr_en = 1'b1;
                    if (cnt_r >= CNT_W'(WIN_LEN-1)) emit_pre = 1'b1;
                    if (cnt_r == CNT_W'(LAST_PRE))  st_nxt = ST_PRE_WAIT;
                end
            end
            ST_PRE_WAIT: begin
                if (align_valid) st_nxt = ST_ARM;
            end
            ST_ARM: begin
                if (smp_valid)
                    st_nxt = (dly_hold_r == '0) ? ST_DATA : ST_GUARD;
            end
            ST_GUARD: begin
                if (smp_valid && dly_r == DELAY_W'(1)) st_nxt = ST_DATA;
            end
            ST_DATA: begin
                if (smp_valid) begin
                    wr_en = 1'b1;
                    if (cnt_r == CNT_W'(WIN_LEN-1)) emit_dat = 1'b1;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
        if (restart) begin
            st_nxt   = ST_IDLE;
            wr_en    = 1'b0;
            emit_pre = 1'b0;
            emit_dat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_r      <= '0;
            dly_hold_r <= '0;
            dly_r      <= '0;
        end else if (restart) begin
            cnt_r      <= '0;
            dly_hold_r <= '0;
            dly_r      <= '0;
        end else begin
            unique case (st_r)
                ST_IDLE: if (smp_valid) cnt_r <= CNT_W'(1);
                ST_PRE:  if (smp_valid) cnt_r <= cnt_r + 1'b1;
                ST_PRE_WAIT: begin
                    cnt_r <= '0;
                    if (align_valid) dly_hold_r <= align_delay;
                end
                ST_ARM:   if (smp_valid) dly_r <= dly_hold_r;
                ST_GUARD: if (smp_valid) dly_r <= dly_r - 1'b1;
                ST_DATA: begin
                    if (smp_valid)
                        cnt_r <= (cnt_r == CNT_W'(WIN_LEN-1)) ? '0 : cnt_r + 1'b1;
                end
                default: cnt_r <= '0;
            endcase
        end
    end
endmodule

// File: rtl/sample_window_acq.sv
module sample_window_acq #(
    parameter int SAMPLE_W    = 12,
    parameter int WIN_LEN     = 8,
    parameter int PRE_WINDOWS = 112,
    parameter int DELAY_W     = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             restart,
    input  logic                             smp_valid,
    input  logic [SAMPLE_W-1:0]              smp_data,
    input  logic                             align_valid,
    input  logic [DELAY_W-1:0]               align_delay,
    output logic                             pre_win_valid,
    output logic [WIN_LEN-1:0][SAMPLE_W-1:0] pre_win,
    output logic                             dat_win_valid,
    output logic [WIN_LEN-1:0][SAMPLE_W-1:0] dat_win
);
    logic wr_en, emit_pre, emit_dat;
    logic [WIN_LEN-1:0][SAMPLE_W-1:0] next_win;

    swa_ctrl #(
        .WIN_LEN    (WIN_LEN),
        .PRE_WINDOWS(PRE_WINDOWS),
        .DELAY_W    (DELAY_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .smp_valid  (smp_valid),
        .align_valid(align_valid),
        .align_delay(align_delay),
        .wr_en      (wr_en),
        .emit_pre   (emit_pre),
        .emit_dat   (emit_dat)
    );

    swa_ring #(
        .SAMPLE_W(SAMPLE_W),
        .WIN_LEN (WIN_LEN)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .wr_en   (wr_en),
        .wr_data (smp_data),
        .next_win(next_win)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_win_valid <= 1'b0;
            dat_win_valid <= 1'b0;
            pre_win       <= '0;
            dat_win       <= '0;
        end else begin
            pre_win_valid <= emit_pre;
            dat_win_valid <= emit_dat;
            if (emit_pre) pre_win <= next_win;
            if (emit_dat) dat_win <= next_win;
        end
    end
endmodule

// File: rtl/sample_window_acq_chk.sv
module sample_window_acq_chk #(
    parameter int SAMPLE_W = 12,
    parameter int WIN_LEN  = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             restart,
    input logic                             smp_valid,
    input logic [SAMPLE_W-1:0]              smp_data,
    input logic                             pre_win_valid,
    input logic [WIN_LEN-1:0][SAMPLE_W-1:0] pre_win,
    input logic                             dat_win_valid,
    input logic [WIN_LEN-1:0][SAMPLE_W-1:0] dat_win
);
    AST_ONE_VALID_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_win_valid, dat_win_valid})); // R8

    AST_WIN_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_win_valid || dat_win_valid) |-> $past(smp_valid && !restart)); // R8

    AST_QUIET_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !(pre_win_valid || dat_win_valid)); // R9

    AST_PRE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pre_win_valid |-> pre_win[WIN_LEN-1] == $past(smp_data)); // R2

    AST_DAT_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        dat_win_valid |-> dat_win[WIN_LEN-1] == $past(smp_data)); // R7

    AST_PRE_SLIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_win_valid && $past(pre_win_valid)) |->
            pre_win[WIN_LEN-2:0] == $past(pre_win[WIN_LEN-1:1])); // R3

    AST_DAT_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        dat_win_valid |=> !dat_win_valid); // R7
endmodule

bind sample_window_acq sample_window_acq_chk #(
    .SAMPLE_W(SAMPLE_W),
    .WIN_LEN (WIN_LEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (restart),
    .smp_valid    (smp_valid),
    .smp_data     (smp_data),
    .pre_win_valid(pre_win_valid),
    .pre_win      (pre_win),
    .dat_win_valid(dat_win_valid),
    .dat_win      (dat_win)
);

// File: tb/test_sample_window_acq.sv
module test_sample_window_acq;
    localparam int SW = 12;
    localparam int WL = 8;
    localparam int PW = 12;
    localparam int DW = 3;

    typedef struct {
        bit                      is_dat;
        logic [WL-1:0][SW-1:0]   win;
        string                   tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart = 1'b0;
    logic smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic align_valid = 1'b0;
    logic [DW-1:0] align_delay = '0;
    logic pre_win_valid, dat_win_valid;
    logic [WL-1:0][SW-1:0] pre_win, dat_win;

    int n_cmp = 0;
    int n_bad = 0;
    int n_win = 0;
    exp_t exp_q[$];
    int hist[$];
    int dbuf[$];
    int next_val = 1;

    always #4 clk = ~clk;

    sample_window_acq #(
        .SAMPLE_W(SW), .WIN_LEN(WL), .PRE_WINDOWS(PW), .DELAY_W(DW)
    ) i_sample_window_acq (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .align_valid(align_valid), .align_delay(align_delay),
        .pre_win_valid(pre_win_valid), .pre_win(pre_win),
        .dat_win_valid(dat_win_valid), .dat_win(dat_win)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: pops the expected window for every pulse seen.
    always @(negedge clk) begin
        if (rst_n && (pre_win_valid || dat_win_valid)) begin
            n_win++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", $sformatf("unexpected window actual pre=%0b dat=%0b expected none",
                      pre_win_valid, dat_win_valid));
            end else begin
                exp_t e;
                logic [WL-1:0][SW-1:0] got;
                e = exp_q.pop_front();
                got = e.is_dat ? dat_win : pre_win;
                check((e.is_dat ? dat_win_valid : pre_win_valid) == 1'b1 && got == e.win, e.tag,
                      $sformatf("kind_dat=%0b actual %h expected %h", e.is_dat, got, e.win));
            end
        end
    end

    task automatic drive(input int v);
        smp_valid = 1'b1;
        smp_data  = SW'(v);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Preamble sample: after WL samples each one yields a sliding window (R2, R3).
    task automatic pre_sample(input string tag);
        int v = next_val++;
        hist.push_back(v);
        if (hist.size() >= WL) begin
            exp_t e;
            e.is_dat = 1'b0;
            e.tag = tag;
            for (int i = 0; i < WL; i++) e.win[i] = SW'(hist[hist.size()-WL+i]);
            exp_q.push_back(e);
        end
        drive(v);
    endtask

    task automatic drop_sample();
        drive(next_val++);
    endtask

    // Data sample: every WL samples form one window (R7).
    task automatic dat_sample(input string tag);
        int v = next_val++;
        dbuf.push_back(v);
        if (dbuf.size() == WL) begin
            exp_t e;
            e.is_dat = 1'b1;
            e.tag = tag;
            for (int i = 0; i < WL; i++) e.win[i] = SW'(dbuf[i]);
            exp_q.push_back(e);
            dbuf.delete();
        end
        drive(v);
    endtask

    task automatic pulse_align(input int d);
        align_valid = 1'b1;
        align_delay = DW'(d);
        @(negedge clk);
        align_valid = 1'b0;
        align_delay = '0;
    endtask

    task automatic do_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        check(!pre_win_valid && !dat_win_valid, "R9",
              $sformatf("after restart actual valids %0b%0b expected 00", pre_win_valid, dat_win_valid));
        hist.delete();
        dbuf.delete();
    endtask

    task automatic run_preamble();
        for (int k = 0; k < WL + PW - 1; k++) pre_sample(k < WL ? "R2" : "R3");
        @(negedge clk);
    endtask

    task automatic skip_and_data(input int d, input int nwin);
        pulse_align(d);
        for (int k = 0; k <= d; k++) drop_sample();       // R6
        for (int k = 0; k < nwin * WL; k++) dat_sample("R6");
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pre_win_valid && !dat_win_valid, "R1",
              $sformatf("reset valids actual %0b%0b expected 00", pre_win_valid, dat_win_valid));

        // First preamble with a stray alignment pulse in the middle (R5).
        for (int k = 0; k < 10; k++) pre_sample(k < WL ? "R2" : "R3");
        pulse_align(5);
        for (int k = 10; k < WL + PW - 1; k++) pre_sample("R5");
        @(negedge clk);
        // Samples in the waiting state must give no window (R4).
        seen = n_win;
        for (int k = 0; k < 3; k++) drop_sample();
        @(negedge clk);
        check(n_win == PW && seen == n_win, "R4",
              $sformatf("window count actual %0d expected %0d", n_win, PW));

        // Offset 2 -> skip 3, two data windows, then stray align ignored (R5).
        pulse_align(2);
        for (int k = 0; k < 3; k++) drop_sample();
        for (int k = 0; k < 2 * WL; k++) dat_sample("R7");
        pulse_align(6);
        for (int k = 0; k < WL; k++) dat_sample("R5");
        for (int k = 0; k < 4; k++) dat_sample("R9");   // partial block then restart
        @(negedge clk);
        do_restart();
        dbuf.delete();

        // Second run: offset 0 skips exactly one sample.
        run_preamble();
        skip_and_data(0, 2);
        do_restart();

        // Third run: largest offset skips WL samples.
        run_preamble();
        skip_and_data(7, 1);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R8",
              $sformatf("pending windows actual %0d expected 0", exp_q.size()));
        summary();
        $finish;
    end
endmodule